// File: doc/BRIEF.md
# Oscillator Mode and Command Controller

This block sits behind a single-wire serial receiver in a programmable oscillator. The receiver delivers whole bytes together with three strobes: one for a finished byte frame, one for a recognised setup sequence and one for an aborted transaction. From these the controller assembles commands made of one opcode byte and zero to four argument bytes. It then runs the output-mode state machine and holds the active configuration. That configuration is a base-frequency word, a signed frequency offset, a drive-strength code and a choice between low power and low jitter.

The controller reports the current mode and drives an output-enable and a tri-state control for the clock pad. When the frequency changes, the output is blanked during recalibration. The `settle_done_i` input stands in for the end of that recalibration. When the clock output is turned off, it turns off only at an output-clock cycle boundary, which `clk_cycle_end_i` marks. Settings written while the output is parked in Stop or Doze are kept as pending values and take effect on the way back to Run.

Top module: `oscm_ctrl`

## Requirements
- R1: After reset the mode is Setup with the factory configuration: base frequency 0x4B189680, offset 0, drive code 3 and low jitter 0. In Setup the output is driven but disabled (out_en 0, out_hiz 0). A `settle_done_i` pulse in Setup moves the mode to Run and sets out_en to 1 on the same edge. Mode codes are Setup 0, Run 1, Stop 2, Doze 3, Sleep 4.
- R2: The opcodes and their argument byte counts are: 0x50 Run (0), 0x18 Stop (0), 0x20 Doze (0), 0x30 Sleep (0), 0x0C NewFreq (4), 0x10 OriginalFreq (0), 0x3A OffsetFreq (2), 0x41 DrvStrength (1), 0x49 PwrJitter (1), 0x00 No-op (0). Any other opcode is dropped, and the next byte is read as an opcode.
- R3: A command acts only once its last argument byte has arrived. A setup strobe that arrives while arguments are still expected throws the partial command away.
- R4: The NewFreq argument is loaded into the base-frequency word with the first byte as the most significant byte. The OffsetFreq argument is loaded into the offset word in the same byte order.
- R5: OffsetFreq overwrites the offset. It does not accumulate. NewFreq and OriginalFreq both reset the offset to zero. OriginalFreq restores the factory base frequency.
- R6: NewFreq or OriginalFreq received in Run moves the mode to Setup. `settle_done_i` then returns it to Run.
- R7: In Stop or Doze, frequency and offset commands change no output. The last value written is applied when the mode next leaves Stop or Doze for Run. If a frequency is pending, that exit goes through Setup.
- R8: In Sleep, every received byte is ignored. A `wake_i` pulse moves Sleep to Setup, keeping the retained configuration.
- R9: A PwrJitter value (bit 0: 0 low power, 1 low jitter) stays pending until the next entry into Setup. A Run command received while in Run moves the mode to Setup.
- R10: out_en falls only on an edge where `clk_cycle_end_i` is high. out_hiz is 1 only in Stop, Doze or Sleep, and it too is set on a cycle-end edge.
- R11: An abort strobe clears the argument count and the partly assembled argument, so the next byte is read as an opcode.
- R12: A DrvStrength value of 0 to 7 takes effect at once. A larger value leaves the drive code unchanged.
- R13: Setup exits only to Run. Stop, Doze and Sleep commands are accepted in Run, Stop or Doze. In Setup, every command except DrvStrength and PwrJitter is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_byte_i | input | 8 | Byte from the serial receiver |
| rx_byte_valid_i | input | 1 | One-cycle strobe: rx_byte_i holds a finished frame |
| rx_setup_i | input | 1 | One-cycle strobe: setup sequence recognised |
| rx_abort_i | input | 1 | One-cycle strobe: receiver aborted the transaction |
| wake_i | input | 1 | Data-line edge seen while sleeping |
| settle_done_i | input | 1 | Recalibration finished |
| clk_cycle_end_i | input | 1 | Output clock is at a cycle boundary |
| mode_o | output | 3 | Current mode code |
| out_en_o | output | 1 | Output clock enable |
| out_hiz_o | output | 1 | Output pad tri-state |
| base_freq_o | output | 32 | Active base-frequency word |
| freq_offset_o | output | 16 | Active signed offset word |
| drive_code_o | output | 3 | Active drive-strength code |
| low_jitter_o | output | 1 | Active power/jitter selection |

## Verification
The bench sends an unknown opcode immediately before a Stop. A parser that did not return to opcode wait would swallow the Stop as an argument and stay in Run. It sends a setup strobe, and separately an abort, partway through a NewFreq, and then an OffsetFreq. A design that kept the partial state would load a corrupted base frequency or read the OffsetFreq opcode as data.

In Stop, the bench writes two frequencies and then an offset. A design that applied them immediately, kept the first frequency instead of the last, or let the frequency clear overwrite the later offset would show wrong words, either while parked or after Run resumes. The remaining cases probe the corners of the mode machine. A Run byte is sent during Sleep, and a design that did not block it would leave Sleep. Run is sent while already in Run, and a design that missed it would never apply the pending jitter setting. An out-of-range drive code is written, and a design without the range check would change the drive code.

// File: rtl/oscm_pkg.sv
package oscm_pkg;

    typedef enum logic [2:0] {
        M_SETUP = 3'd0,
        M_RUN   = 3'd1,
        M_STOP  = 3'd2,
        M_DOZE  = 3'd3,
        M_SLEEP = 3'd4
    } mode_e;

    localparam logic [7:0] OP_RUN    = 8'h50;
    localparam logic [7:0] OP_STOP   = 8'h18;
    localparam logic [7:0] OP_DOZE   = 8'h20;
    localparam logic [7:0] OP_SLEEP  = 8'h30;
    localparam logic [7:0] OP_NEWF   = 8'h0C;
    localparam logic [7:0] OP_ORIGF  = 8'h10;
    localparam logic [7:0] OP_OFFS   = 8'h3A;
    localparam logic [7:0] OP_DRIVE  = 8'h41;
    localparam logic [7:0] OP_PWRJ   = 8'h49;
    localparam logic [7:0] OP_NOP    = 8'h00;

    function automatic logic op_known(input logic [7:0] op);
        case (op)
            OP_RUN, OP_STOP, OP_DOZE, OP_SLEEP, OP_NEWF,
            OP_ORIGF, OP_OFFS, OP_DRIVE, OP_PWRJ, OP_NOP: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [2:0] op_args(input logic [7:0] op);
        case (op)
            OP_NEWF:           return 3'd4;
            OP_OFFS:           return 3'd2;
            OP_DRIVE, OP_PWRJ: return 3'd1;
            default:           return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/oscm_cmd_parser.sv
module oscm_cmd_parser
    import oscm_pkg::*;
#(
    parameter int ARG_BYTES = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [7:0]             byte_i,
    input  logic                   byte_v_i,
    input  logic                   setup_i,
    input  logic                   abort_i,
    input  logic                   block_i,
    output logic                   cmd_v_o,
    output logic [7:0]             cmd_op_o,
    output logic [8*ARG_BYTES-1:0] cmd_arg_o
);
    localparam int AW = 8 * ARG_BYTES;
    localparam int CW = $clog2(ARG_BYTES + 1);

    typedef struct packed {
        logic          busy;
        logic [7:0]    op;
        logic [CW-1:0] left;
        logic [AW-1:0] arg;
        logic          cmd_v;
        logic [7:0]    cmd_op;
        logic [AW-1:0] cmd_arg;
    } pstate_t;

    pstate_t q, d;

    always_comb begin
        d       = q;
        d.cmd_v = 1'b0;
        if (setup_i || abort_i) begin
            d.busy = 1'b0;
            d.left = '0;
            d.arg  = '0;
        end else if (byte_v_i && !block_i) begin
            if (!q.busy) begin
                if (op_known(byte_i)) begin
                    if (op_args(byte_i) == 3'd0) begin
                        d.cmd_v   = 1'b1;
                        d.cmd_op  = byte_i;
                        d.cmd_arg = '0;
                    end else begin
                        d.busy = 1'b1;
                        d.op   = byte_i;
                        d.left = CW'(op_args(byte_i));
                        d.arg  = '0;
                    end
                end
            end else begin
                d.arg  = {q.arg[AW-9:0], byte_i};
                d.left = q.left - CW'(1);
                if (q.left == CW'(1)) begin
                    d.busy    = 1'b0;
                    d.cmd_v   = 1'b1;
                    d.cmd_op  = q.op;
                    d.cmd_arg = d.arg;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign cmd_v_o   = q.cmd_v;
    assign cmd_op_o  = q.cmd_op;
    assign cmd_arg_o = q.cmd_arg;

    assert_arg_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.left <= CW'(ARG_BYTES));
    assert_sleep_deaf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        block_i |=> !q.cmd_v);
    assert_abort_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (abort_i || setup_i) |=> (!q.busy && q.left == '0 && !q.cmd_v));
    assert_wait_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.busy && q.left > CW'(1) && byte_v_i) |=> !q.cmd_v);

endmodule

// File: rtl/oscm_mode_fsm.sv
module oscm_mode_fsm
    import oscm_pkg::*;
#(
    parameter int              FW            = 32,
    parameter int              OW            = 16,
    parameter int              DW            = 3,
    parameter logic [FW-1:0]   FACTORY_FREQ  = 32'h4B18_9680,
    parameter logic [DW-1:0]   FACTORY_DRIVE = 3'd3,
    parameter logic            FACTORY_LJ    = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cmd_v_i,
    input  logic [7:0]    cmd_op_i,
    input  logic [FW-1:0] cmd_arg_i,
    input  logic          settle_i,
    input  logic          wake_i,
    input  logic          cyc_end_i,
    output mode_e         mode_o,
    output logic          out_en_o,
    output logic          out_hiz_o,
    output logic [FW-1:0] base_o,
    output logic [OW-1:0] off_o,
    output logic [DW-1:0] drv_o,
    output logic          lj_o
);
    typedef struct packed {
        mode_e         mode;
        logic          out_en;
        logic          hiz;
        logic [FW-1:0] base;
        logic [OW-1:0] off;
        logic [DW-1:0] drv;
        logic          lj;
        logic          pend_lj;
        logic [FW-1:0] pend_base;
        logic          pend_freq;
        logic [OW-1:0] pend_off;
        logic          pend_off_set;
    } fstate_t;

    fstate_t q, d;
    logic          parked;
    logic [FW-1:0] new_base;

    always_comb begin
        d        = q;
        parked   = (q.mode == M_STOP) || (q.mode == M_DOZE);
        new_base = (cmd_op_i == OP_NEWF) ? cmd_arg_i : FACTORY_FREQ;

        if (cmd_v_i) begin
            case (cmd_op_i)
                OP_RUN: begin
                    if (q.mode == M_RUN) d.mode = M_SETUP;
                    else if (parked)     d.mode = q.pend_freq ? M_SETUP : M_RUN;
                end
                OP_STOP, OP_DOZE, OP_SLEEP: begin
                    if (q.mode == M_RUN || parked)
                        d.mode = (cmd_op_i == OP_STOP) ? M_STOP :
                                 (cmd_op_i == OP_DOZE) ? M_DOZE : M_SLEEP;
                end
                OP_NEWF, OP_ORIGF: begin
                    if (q.mode == M_RUN) begin
                        d.base = new_base;
                        d.off  = '0;
                        d.mode = M_SETUP;
                    end else if (parked) begin
                        d.pend_base    = new_base;
                        d.pend_freq    = 1'b1;
                        d.pend_off     = '0;
                        d.pend_off_set = 1'b1;
                    end
                end
                OP_OFFS: begin
                    if (q.mode == M_RUN) begin
                        d.off = cmd_arg_i[OW-1:0];
                    end else if (parked) begin
                        d.pend_off     = cmd_arg_i[OW-1:0];
                        d.pend_off_set = 1'b1;
                    end
                end
                OP_DRIVE: if (cmd_arg_i < FW'(2 ** DW)) d.drv = cmd_arg_i[DW-1:0];
                OP_PWRJ:  d.pend_lj = cmd_arg_i[0];
                default: ;
            endcase
        end

        if (q.mode == M_SETUP && settle_i) d.mode = M_RUN;
        if (q.mode == M_SLEEP && wake_i)   d.mode = M_SETUP;

        if (cyc_end_i && q.mode != M_RUN) begin
            d.out_en = 1'b0;
            if (q.mode != M_SETUP) d.hiz = 1'b1;
        end

        if ((d.mode == M_SETUP || d.mode == M_RUN) && d.mode != q.mode) begin
            d.hiz = 1'b0;
            if (q.pend_freq) begin
                d.base      = q.pend_base;
                d.pend_freq = 1'b0;
            end
            if (q.pend_off_set) begin
                d.off          = q.pend_off;
                d.pend_off_set = 1'b0;
            end
            if (d.mode == M_SETUP) d.lj = q.pend_lj;
            else                   d.out_en = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q         <= '0;
            q.mode    <= M_SETUP;
            q.base    <= FACTORY_FREQ;
            q.drv     <= FACTORY_DRIVE;
            q.lj      <= FACTORY_LJ;
            q.pend_lj <= FACTORY_LJ;
        end else begin
            q <= d;
        end
    end

    assign mode_o    = q.mode;
    assign out_en_o  = q.out_en;
    assign out_hiz_o = q.hiz;
    assign base_o    = q.base;
    assign off_o     = q.off;
    assign drv_o     = q.drv;
    assign lj_o      = q.lj;

    assert_setup_exit_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.mode == M_SETUP) |=> (q.mode == M_SETUP || q.mode == M_RUN));
    assert_clean_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q.out_en) |-> $past(cyc_end_i));
    assert_hiz_parked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.hiz |-> (q.mode == M_STOP || q.mode == M_DOZE || q.mode == M_SLEEP));
    assert_offset_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_v_i && cmd_op_i == OP_NEWF && q.mode == M_RUN) |=> (q.off == '0));
    assert_lj_on_setup_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(q.lj) |-> (q.mode == M_SETUP && $past(q.mode) != M_SETUP));

endmodule

// File: rtl/oscm_ctrl.sv
module oscm_ctrl
    import oscm_pkg::*;
#(
    parameter int               ARG_BYTES     = 4,
    parameter int               OFF_W         = 16,
    parameter int               DRV_W         = 3,
    parameter logic [8*ARG_BYTES-1:0] FACTORY_FREQ = 32'h4B18_9680,
    parameter logic [DRV_W-1:0] FACTORY_DRIVE = 3'd3,
    parameter logic             FACTORY_LJ    = 1'b0
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [7:0]               rx_byte_i,
    input  logic                     rx_byte_valid_i,
    input  logic                     rx_setup_i,
    input  logic                     rx_abort_i,
    input  logic                     wake_i,
    input  logic                     settle_done_i,
    input  logic                     clk_cycle_end_i,
    output logic [2:0]               mode_o,
    output logic                     out_en_o,
    output logic                     out_hiz_o,
    output logic [8*ARG_BYTES-1:0]   base_freq_o,
    output logic [OFF_W-1:0]         freq_offset_o,
    output logic [DRV_W-1:0]         drive_code_o,
    output logic                     low_jitter_o
);
    localparam int FREQ_W = 8 * ARG_BYTES;

    logic              cmd_v;
    logic [7:0]        cmd_op;
    logic [FREQ_W-1:0] cmd_arg;
    mode_e             mode;

    oscm_cmd_parser #(.ARG_BYTES(ARG_BYTES)) u_parser (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .byte_i    (rx_byte_i),
        .byte_v_i  (rx_byte_valid_i),
        .setup_i   (rx_setup_i),
        .abort_i   (rx_abort_i),
        .block_i   (mode == M_SLEEP),
        .cmd_v_o   (cmd_v),
        .cmd_op_o  (cmd_op),
        .cmd_arg_o (cmd_arg)
    );

    oscm_mode_fsm #(
        .FW(FREQ_W), .OW(OFF_W), .DW(DRV_W),
        .FACTORY_FREQ(FACTORY_FREQ), .FACTORY_DRIVE(FACTORY_DRIVE),
        .FACTORY_LJ(FACTORY_LJ)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cmd_v_i   (cmd_v),
        .cmd_op_i  (cmd_op),
        .cmd_arg_i (cmd_arg),
        .settle_i  (settle_done_i),
        .wake_i    (wake_i),
        .cyc_end_i (clk_cycle_end_i),
        .mode_o    (mode),
        .out_en_o  (out_en_o),
        .out_hiz_o (out_hiz_o),
        .base_o    (base_freq_o),
        .off_o     (freq_offset_o),
        .drv_o     (drive_code_o),
        .lj_o      (low_jitter_o)
    );

    assign mode_o = mode;

endmodule

// File: tb/tb_oscm_ctrl.sv
module tb_oscm_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_v = 1'b0, rx_setup = 1'b0, rx_abort = 1'b0;
    logic        wake = 1'b0, settle = 1'b0, cyc_end = 1'b0;
    logic [2:0]  mode;
    logic        out_en, out_hiz, lj;
    logic [31:0] base;
    logic [15:0] off;
    logic [2:0]  drv;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    oscm_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .rx_byte_i(rx_byte), .rx_byte_valid_i(rx_v),
        .rx_setup_i(rx_setup), .rx_abort_i(rx_abort), .wake_i(wake),
        .settle_done_i(settle), .clk_cycle_end_i(cyc_end),
        .mode_o(mode), .out_en_o(out_en), .out_hiz_o(out_hiz),
        .base_freq_o(base), .freq_offset_o(off), .drive_code_o(drv),
        .low_jitter_o(lj)
    );

    typedef struct {
        logic [2:0]  mode;
        logic        en;
        logic        hiz;
        logic [31:0] base;
        logic [15:0] off;
        logic [2:0]  drv;
        logic        lj;
        string       tag;
    } exp_t;

    exp_t sbq[$];

    // expected model, set by hand from the requirements
    logic [2:0]  e_mode = 3'd0;
    logic        e_en = 1'b0, e_hiz = 1'b0, e_lj = 1'b0;
    logic [31:0] e_base = 32'h4B18_9680;
    logic [15:0] e_off = 16'h0;
    logic [2:0]  e_drv = 3'd3;

    localparam logic [2:0] SETUP = 3'd0, RUN = 3'd1, STOP = 3'd2, DOZE = 3'd3, SLEEP = 3'd4;

    // output-clock cycle boundary every fourth cycle
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 cyc_end = 1'b1;
            @(posedge clk);
            #1 cyc_end = 1'b0;
        end
    end

    // monitor: pops one expected item per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if ({mode, out_en, out_hiz, base, off, drv, lj} !==
                    {e.mode, e.en, e.hiz, e.base, e.off, e.drv, e.lj}) begin
                    fails++;
                    $display("FAIL %s: got mode=%0d en=%b hiz=%b base=%h off=%h drv=%0d lj=%b exp mode=%0d en=%b hiz=%b base=%h off=%h drv=%0d lj=%b",
                             e.tag, mode, out_en, out_hiz, base, off, drv, lj,
                             e.mode, e.en, e.hiz, e.base, e.off, e.drv, e.lj);
                end
            end
        end
    end

    task automatic chk(input string tag);
        exp_t e;
        e.mode = e_mode; e.en = e_en; e.hiz = e_hiz; e.base = e_base;
        e.off = e_off; e.drv = e_drv; e.lj = e_lj; e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1 rx_byte = b; rx_v = 1'b1;
        @(posedge clk); #1 rx_v = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic strobe_setup();
        @(posedge clk); #1 rx_setup = 1'b1;
        @(posedge clk); #1 rx_setup = 1'b0;
    endtask

    task automatic strobe_abort();
        @(posedge clk); #1 rx_abort = 1'b1;
        @(posedge clk); #1 rx_abort = 1'b0;
    endtask

    task automatic do_settle();
        @(posedge clk); #1 settle = 1'b1;
        @(posedge clk); #1 settle = 1'b0;
        repeat (2) @(posedge clk); #1;
    endtask

    task automatic do_wake();
        @(posedge clk); #1 wake = 1'b1;
        @(posedge clk); #1 wake = 1'b0;
    endtask

    task automatic gap();
        repeat (6) @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset state");

        do_settle();
        e_mode = RUN; e_en = 1'b1;
        chk("R1 settle to run");

        send(8'h3A); send(8'h12); send(8'h34); gap();
        e_off = 16'h1234;
        chk("R4 offset msb first");

        send(8'h3A); send(8'hFF); send(8'hFE); gap();
        e_off = 16'hFFFE;
        chk("R5 offset replaces");

        send(8'h41); send(8'h05); gap();
        e_drv = 3'd5;
        chk("R12 drive valid");
        send(8'h41); send(8'h09); gap();
        chk("R12 drive above 7 ignored");

        send(8'h49); send(8'h01); gap();
        chk("R9 pwrjitter pending");

        send(8'h77); send(8'h18); gap();
        e_mode = STOP; e_en = 1'b0; e_hiz = 1'b1;
        chk("R2 unknown op ignored then stop, R10 tri-state");

        send(8'h0C); send(8'h44); send(8'h7A); send(8'h00); send(8'h00); gap();
        chk("R7 newfreq deferred in stop");
        send(8'h0C); send(8'h45); send(8'h00); send(8'h00); send(8'h00);
        send(8'h3A); send(8'h00); send(8'h10); gap();
        chk("R7 offset deferred in stop");

        send(8'h50); gap();
        e_mode = SETUP; e_hiz = 1'b0; e_base = 32'h4500_0000; e_off = 16'h0010; e_lj = 1'b1;
        chk("R7 last pending applied via setup, R9 lj applied");
        do_settle();
        e_mode = RUN; e_en = 1'b1;
        chk("R6 settle back to run");

        send(8'h0C); send(8'h11); send(8'h22); strobe_setup();
        send(8'h3A); send(8'h00); send(8'h05); gap();
        e_off = 16'h0005;
        chk("R3 setup discards partial newfreq");

        send(8'h0C); send(8'h33); strobe_abort();
        send(8'h3A); send(8'h00); send(8'h07); gap();
        e_off = 16'h0007;
        chk("R11 abort clears argument count");

        send(8'h0C); send(8'h42); send(8'h48); send(8'h00); send(8'h00); gap();
        e_mode = SETUP; e_en = 1'b0; e_base = 32'h4248_0000; e_off = 16'h0;
        chk("R6 newfreq in run goes to setup, R5 offset cleared");
        send(8'h18); gap();
        chk("R13 stop ignored in setup");
        do_settle();
        e_mode = RUN; e_en = 1'b1;
        chk("R6 run after recalibration");

        send(8'h30); gap();
        e_mode = SLEEP; e_en = 1'b0; e_hiz = 1'b1;
        chk("R8 sleep entered");
        send(8'h50); gap();
        chk("R8 run byte ignored in sleep");
        do_wake(); gap();
        e_mode = SETUP; e_hiz = 1'b0;
        chk("R8 wake to setup retains config");
        do_settle();
        e_mode = RUN; e_en = 1'b1;
        chk("R8 back in run");

        send(8'h49); send(8'h00); gap();
        chk("R9 lj unchanged while pending");
        send(8'h50); gap();
        e_mode = SETUP; e_en = 1'b0; e_lj = 1'b0;
        chk("R9 run in run passes setup");
        do_settle();
        e_mode = RUN; e_en = 1'b1;

        send(8'h3A); send(8'h01); send(8'h00);
        send(8'h10); gap();
        e_mode = SETUP; e_en = 1'b0; e_base = 32'h4B18_9680; e_off = 16'h0;
        chk("R5 originalfreq restores factory and clears offset");
        do_settle();
        e_mode = RUN; e_en = 1'b1;

        send(8'h20); gap();
        e_mode = DOZE; e_en = 1'b0; e_hiz = 1'b1;
        chk("R13 doze from run, R10 tri-state");
        send(8'h00); send(8'h50); gap();
        e_mode = RUN; e_en = 1'b1; e_hiz = 1'b0;
        chk("R2 nop then R7 run from doze without pending");

        done = 1'b1;
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule